// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Counter

This block sits between a low-side current comparator and the gate-control logic of a synchronous buck converter. It decides when an overcurrent condition is serious enough to stop switching. The comparator output is qualified in three ways. It counts only while the low-side switch is on. It counts only after a blanking interval has passed since that switch turned on. It is ignored while the block is disabled or in fault. A qualified trip opens an overcurrent event. While the event lasts, the block requests that the low-side switch stay on. The event closes as soon as the qualified comparator reads below threshold.

A saturating up/down counter is updated on every PWM cycle tick. It goes up by one if any qualified trip was seen during that cycle, and down by one otherwise. It never goes below zero. When the count reaches the trip level, the block enters hiccup fault mode. In fault mode both switches are forced off for a fixed number of PWM cycles. The block then leaves fault mode and pulses a restart request to the soft-start logic. The counter starts again from zero, so a persistent overload produces a repeating fault, wait and restart sequence. A brief overload never disturbs regulation. Driving enable low clears the whole block.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset, and in any cycle after enable was low at the preceding clock edge, `fault`, `force_off`, `ls_hold` and `restart` are all 0.
- R2: `oc_raw` is ignored while `ls_on` is 0. It is also ignored during the first BLANK_CYC (default 8) clock edges of each interval in which `ls_on` is 1. A trip sampled at edge offset d (counting from 0 at the first edge with `ls_on` high) is qualified only when d >= BLANK_CYC.
- R3: `ls_hold` becomes 1 in the cycle after a qualified trip. It returns to 0 in the cycle after the comparator is sampled low with `ls_on` high and blanking over.
- R4: On each `pwm_tick`, the counter increments if a qualified trip occurred since the previous tick (including the tick cycle itself), and decrements otherwise. `fault` becomes 1 in the cycle after the tick that takes the count to TRIP_COUNT (default 7).
- R5: The counter saturates at 0. Downward ticks at zero leave it at zero, so TRIP_COUNT net upward ticks are then still needed to reach fault.
- R6: `force_off` equals `fault`. While in fault, `ls_hold` is 0 and comparator trips do not count.
- R7: Fault lasts exactly HICCUP_CYC (default 15) ticks after the entry tick. On the edge of the last of these ticks, `fault` drops and `restart` is 1 for exactly one clock cycle.
- R8: After a restart the counter starts from 0. A continuing overload re-enters fault after TRIP_COUNT more tripped cycles, and the sequence repeats.
- R9: Driving `enable` low for one cycle clears the counter, the event and the fault, without producing a `restart` pulse.
- R10: A sequence of PWM cycles whose saturating count never reaches TRIP_COUNT never raises `fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all state |
| pwm_tick | input | 1 | One-clock pulse per PWM cycle |
| ls_on | input | 1 | Low-side switch currently on |
| oc_raw | input | 1 | Raw overcurrent comparator output |
| ls_hold | output | 1 | Request to keep the low-side switch on during an event |
| fault | output | 1 | Hiccup fault mode active |
| force_off | output | 1 | Request to turn both switches off |
| restart | output | 1 | One-clock soft-start restart request |

## Verification
The bench compares the ports against a model computed from the requirements. A counter that wraps below zero, or that misses a step, shows up as a `fault` that comes one or more PWM ticks early or late. The bench checks `fault` right after every tick, so such an error is caught within a single PWM cycle. A wrong blanking length or a stuck event flag appears at `ls_hold` one clock after the comparator sample. A hiccup timer of the wrong length is seen at the tick where `restart` should pulse.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

   typedef enum logic [0:0] {
      HS_RUN    = 1'b0,
      HS_HICCUP = 1'b1
   } hic_state_t;

   function automatic int unsigned cnt_width(input int unsigned top);
      return (top < 2) ? 1 : $clog2(top + 1);
   endfunction

endpackage

// File: rtl/ocp_blank_qual.sv
module ocp_blank_qual #(
   parameter int unsigned BLANK_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ls_on,
   input  logic oc_raw,
   output logic oc_high,
   output logic oc_low
);
   import ocp_hiccup_pkg::*;

   logic window_open;

   generate
      if (BLANK_CYC == 0) begin : g_no_blank
         assign window_open = ls_on & enable;
      end else begin : g_blank
         localparam int unsigned BLK_W = cnt_width(BLANK_CYC);
         localparam logic [BLK_W-1:0] BLK_END = BLK_W'(BLANK_CYC);

         logic [BLK_W-1:0] blank_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               blank_cnt <= '0;
            end else if (!enable || !ls_on) begin
               blank_cnt <= '0;
            end else if (blank_cnt != BLK_END) begin
               blank_cnt <= blank_cnt + 1'b1;
            end
         end

         assign window_open = ls_on & enable & (blank_cnt == BLK_END);
      end
   endgenerate

   assign oc_high = window_open & oc_raw;
   assign oc_low  = window_open & ~oc_raw;

endmodule

// File: rtl/ocp_event_track.sv
module ocp_event_track (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic fault,
   input  logic pwm_tick,
   input  logic oc_high,
   input  logic oc_low,
   output logic event_on,
   output logic oc_seen
);

   logic event_r;
   logic seen_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         event_r <= 1'b0;
      end else if (!enable || fault) begin
         event_r <= 1'b0;
      end else if (oc_high) begin
         event_r <= 1'b1;
      end else if (oc_low) begin
         event_r <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_r <= 1'b0;
      end else if (!enable || fault || pwm_tick) begin
         seen_r <= 1'b0;
      end else if (oc_high) begin
         seen_r <= 1'b1;
      end
   end

   assign event_on = event_r;
   assign oc_seen  = seen_r | oc_high;

endmodule

// File: rtl/ocp_updown_cnt.sv
module ocp_updown_cnt #(
   parameter int unsigned TRIP_COUNT = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic fault,
   input  logic pwm_tick,
   input  logic oc_seen,
   output logic trip
);
   import ocp_hiccup_pkg::*;

   localparam int unsigned CNT_W = cnt_width(TRIP_COUNT);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIP_COUNT - 1);
   localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TRIP_COUNT);

   logic [CNT_W-1:0] cnt;
   logic             active;

   assign active = enable & ~fault;
   assign trip   = active & pwm_tick & oc_seen & (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!active || trip) begin
         cnt <= '0;
      end else if (pwm_tick) begin
         if (oc_seen) begin
            if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq #(
   parameter int unsigned HICCUP_CYC = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pwm_tick,
   input  logic trip,
   output logic fault,
   output logic restart
);
   import ocp_hiccup_pkg::*;

   localparam int unsigned HIC_W = cnt_width(HICCUP_CYC);
   localparam logic [HIC_W-1:0] HIC_LAST = HIC_W'(HICCUP_CYC - 1);

   hic_state_t       state;
   logic [HIC_W-1:0] hic_cnt;
   logic             restart_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= HS_RUN;
         hic_cnt   <= '0;
         restart_r <= 1'b0;
      end else begin
         restart_r <= 1'b0;
         if (!enable) begin
            state   <= HS_RUN;
            hic_cnt <= '0;
         end else begin
            case (state)
               HS_RUN: begin
                  if (trip) begin
                     state   <= HS_HICCUP;
                     hic_cnt <= '0;
                  end
               end
               HS_HICCUP: begin
                  if (pwm_tick) begin
                     if (hic_cnt == HIC_LAST) begin
                        state     <= HS_RUN;
                        hic_cnt   <= '0;
                        restart_r <= 1'b1;
                     end else begin
                        hic_cnt <= hic_cnt + 1'b1;
                     end
                  end
               end
               default: state <= HS_RUN;
            endcase
         end
      end
   end

   assign fault   = (state == HS_HICCUP);
   assign restart = restart_r;

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
   parameter int unsigned BLANK_CYC  = 8,
   parameter int unsigned TRIP_COUNT = 7,
   parameter int unsigned HICCUP_CYC = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pwm_tick,
   input  logic ls_on,
   input  logic oc_raw,
   output logic ls_hold,
   output logic fault,
   output logic force_off,
   output logic restart
);

   generate
      if (TRIP_COUNT < 2) begin : g_bad_trip
         $error("TRIP_COUNT must be at least 2");
      end
      if (HICCUP_CYC < 1) begin : g_bad_hiccup
         $error("HICCUP_CYC must be at least 1");
      end
   endgenerate

   logic oc_high;
   logic oc_low;
   logic event_on;
   logic oc_seen;
   logic trip;
   logic fault_i;

   ocp_blank_qual #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .ls_on   (ls_on),
      .oc_raw  (oc_raw),
      .oc_high (oc_high),
      .oc_low  (oc_low)
   );

   ocp_event_track u_event (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .fault    (fault_i),
      .pwm_tick (pwm_tick),
      .oc_high  (oc_high),
      .oc_low   (oc_low),
      .event_on (event_on),
      .oc_seen  (oc_seen)
   );

   ocp_updown_cnt #(.TRIP_COUNT(TRIP_COUNT)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .fault    (fault_i),
      .pwm_tick (pwm_tick),
      .oc_seen  (oc_seen),
      .trip     (trip)
   );

   ocp_hiccup_seq #(.HICCUP_CYC(HICCUP_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .pwm_tick (pwm_tick),
      .trip     (trip),
      .fault    (fault_i),
      .restart  (restart)
   );

   assign fault     = fault_i;
   assign force_off = fault_i;
   assign ls_hold   = event_on & ~fault_i;

endmodule

// File: rtl/ocp_hiccup_ctrl_chk.sv
module ocp_hiccup_ctrl_chk #(
   parameter int unsigned BLANK_CYC  = 8,
   parameter int unsigned HICCUP_CYC = 15
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic pwm_tick,
   input logic ls_on,
   input logic oc_raw,
   input logic ls_hold,
   input logic fault,
   input logic force_off,
   input logic restart
);

   int unsigned on_cnt;
   int unsigned fault_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_cnt      <= 0;
         fault_ticks <= 0;
      end else begin
         if (!ls_on || !enable) on_cnt <= 0;
         else if (on_cnt < BLANK_CYC) on_cnt <= on_cnt + 1;
         if (!fault) fault_ticks <= 0;
         else if (pwm_tick) fault_ticks <= fault_ticks + 1;
      end
   end

   AST_HOLD_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_hold) |-> $past(ls_on && oc_raw && enable)) else $error("hold without trip"); // R2
   AST_HOLD_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_hold) |-> ($past(on_cnt) == BLANK_CYC)) else $error("hold inside blanking"); // R2
   AST_FAULT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(pwm_tick)) else $error("fault entered off tick"); // R4
   AST_NO_HOLD_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!ls_hold && force_off)) else $error("hold during fault"); // R6
   AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart) else $error("restart wider than one cycle"); // R7
   AST_RESTART_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (!fault && $past(fault) && $past(pwm_tick))) else $error("restart not at fault exit"); // R7
   AST_HICCUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (fault_ticks < HICCUP_CYC)) else $error("fault too long"); // R7
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!fault && !ls_hold && !restart)) else $error("disable did not clear"); // R9

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_ctrl_chk #(
   .BLANK_CYC  (BLANK_CYC),
   .HICCUP_CYC (HICCUP_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .pwm_tick  (pwm_tick),
   .ls_on     (ls_on),
   .oc_raw    (oc_raw),
   .ls_hold   (ls_hold),
   .fault     (fault),
   .force_off (force_off),
   .restart   (restart)
);

// File: tb/test_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module test_ocp_hiccup_ctrl;

   localparam int BLANK = 8;
   localparam int TRIP  = 7;
   localparam int HIC   = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic pwm_tick = 1'b0;
   logic ls_on = 1'b0;
   logic oc_raw = 1'b0;
   logic ls_hold, fault, force_off, restart;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_cnt = 0;
   int m_fault = 0;
   int m_hic = 0;
   int m_rst = 0;

   always #5 clk = ~clk;

   ocp_hiccup_ctrl #(.BLANK_CYC(BLANK), .TRIP_COUNT(TRIP), .HICCUP_CYC(HIC)) i_ocp_hiccup_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_tick(pwm_tick),
      .ls_on(ls_on), .oc_raw(oc_raw), .ls_hold(ls_hold), .fault(fault),
      .force_off(force_off), .restart(restart)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_eq(input string req, input logic act, input int exp);
      chk(act == exp[0], req, int'(act), exp);
   endtask

   task automatic clear_all();
      @(negedge clk);
      enable = 1'b0; ls_on = 1'b0; oc_raw = 1'b0; pwm_tick = 1'b0;
      @(negedge clk);
      chk_eq("R9 fault", fault, 0);
      chk_eq("R9 ls_hold", ls_hold, 0);
      chk_eq("R9 restart", restart, 0);
      enable = 1'b1;
      m_cnt = 0; m_fault = 0; m_hic = 0; m_rst = 0;
   endtask

   // one PWM cycle; oc=1 puts a trip at offset 10 (past blanking)
   task automatic pwm_cycle(input bit oc);
      bit seen;
      seen = oc && (m_fault == 0);
      ls_on = 1'b1;
      for (int i = 0; i < 12; i++) begin
         if (i == 11) chk_eq("R3 hold set", ls_hold, seen ? 1 : 0);
         oc_raw = oc && (i == 10);
         @(negedge clk);
      end
      chk_eq("R3 hold clear", ls_hold, 0);
      ls_on = 1'b0;
      pwm_tick = 1'b1;
      @(negedge clk);
      pwm_tick = 1'b0;
      m_rst = 0;
      if (m_fault != 0) begin
         m_hic++;
         if (m_hic == HIC) begin
            m_fault = 0; m_hic = 0; m_rst = 1;
         end
      end else if (seen) begin
         m_cnt++;
         if (m_cnt == TRIP) begin
            m_fault = 1; m_cnt = 0; m_hic = 0;
         end
      end else if (m_cnt > 0) begin
         m_cnt--;
      end
      chk_eq("R4 fault", fault, m_fault);
      chk_eq("R6 force_off", force_off, m_fault);
      chk_eq("R7 restart", restart, m_rst);
      if (m_rst != 0) begin
         @(negedge clk);
         chk_eq("R7 restart width", restart, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_eq("R1 fault", fault, 0);
      chk_eq("R1 force_off", force_off, 0);
      chk_eq("R1 ls_hold", ls_hold, 0);
      chk_eq("R1 restart", restart, 0);
      rst_n = 1'b1;
      enable = 1'b1;
      @(negedge clk);

      // R2: comparator ignored while low side is off
      oc_raw = 1'b1;
      repeat (12) @(negedge clk);
      chk_eq("R2 ls_on low", ls_hold, 0);
      oc_raw = 1'b0;

      // R2/R3: blanking sweep over trip offset
      for (int d = 0; d < 13; d++) begin
         ls_on = 1'b1;
         for (int i = 0; i <= d; i++) begin
            oc_raw = (i == d);
            @(negedge clk);
         end
         oc_raw = 1'b0;
         chk_eq("R2 blanking", ls_hold, (d >= BLANK) ? 1 : 0);
         @(negedge clk);
         chk_eq("R3 event end", ls_hold, 0);
         ls_on = 1'b0;
         @(negedge clk);
      end
      clear_all();

      // R10: six ups then downs, no fault
      for (int i = 0; i < 6; i++) pwm_cycle(1'b1);
      for (int i = 0; i < 8; i++) pwm_cycle(1'b0);
      chk_eq("R10 no fault", fault, 0);
      clear_all();

      // R5: saturation at zero, then exactly TRIP ups
      for (int i = 0; i < 3; i++) pwm_cycle(1'b0);
      for (int i = 0; i < TRIP - 1; i++) pwm_cycle(1'b1);
      chk_eq("R5 not yet", fault, 0);
      pwm_cycle(1'b1);
      chk_eq("R5 trip", fault, 1);

      // R6/R7/R8: persistent overload through hiccup and re-entry
      for (int i = 0; i < HIC + TRIP + 3; i++) pwm_cycle(1'b1);
      chk_eq("R8 re-entry", fault, m_fault);

      // R9: disable in fault clears with no restart
      clear_all();
      for (int i = 0; i < TRIP - 1; i++) pwm_cycle(1'b1);
      clear_all();
      pwm_cycle(1'b1);
      chk_eq("R9 count cleared", fault, 0);
      clear_all();

      // R10/R4: sweep all 8-bit patterns of tripped cycles
      for (int p = 0; p < 256; p++) begin
         for (int b = 0; b < 8; b++) pwm_cycle(p[b]);
         clear_all();
      end

      // R8: long mixed pattern across several hiccups
      for (int i = 0; i < 60; i++) pwm_cycle((i % 4) != 3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule